// File: doc/BRIEF.md
# Display DMA Input FIFO Buffer

This block sits between a DMA read engine and a display pixel datapath. The DMA engine pushes fetched words into it, and the datapath pulls them out one word per data-request. For each queue the block registers a fetch request that stays high while the queue holds fewer words than a programmable low-water threshold. This lets the DMA engine top the queue up in bursts. With the recommended threshold, total depth minus twice the burst length minus three, bursts already in flight always find room.

A mode input chooses the arrangement. In single-panel mode all of the storage forms one queue of `DEPTH` words, the upper queue. In dual-panel mode the same storage splits into two independent queues of `DEPTH/2` words, one for the upper half of the panel and one for the lower. A panel-select bit on the write port chooses the queue for each word. A change of mode, or a synchronous flush, empties everything. Writes to a full queue and reads from an empty queue are reported through sticky flags.

Top module: `disp_dma_fifo`

## Requirements
- R1: While `rst_n` is low and directly after it rises, both fill levels, both fetch requests, both read-data outputs and both error flags are zero.
- R2: With `dual_mode` = 0, all writes enter the upper queue of capacity `DEPTH`, whatever `wr_panel` is. Words leave in write order. `level_lo` and `dma_req_lo` stay 0, and `rd_req_lo` has no effect on any output.
- R3: With `dual_mode` = 1, a write with `wr_panel` = 0 goes to the upper queue and one with `wr_panel` = 1 goes to the lower queue. Each queue holds at most `DEPTH/2` words and keeps its own write order.
- R4: A read request on a non-empty queue presents the oldest word on that queue's read-data output after the next rising edge, and lowers its level by one.
- R5: After each rising edge, `dma_req_up` equals (upper level before that edge < `fifo_th`). `dma_req_lo` equals `dual_mode` AND (lower level before that edge < `fifo_th`). The request therefore lags the level by one clock.
- R6: A write to a full queue is dropped. The level and the stored words are unchanged, and `overflow` is set and stays set.
- R7: A read from an empty queue leaves that queue's read-data output unchanged and its level at 0, and sets `underflow`, which stays set.
- R8: `clr_err` clears both flags at the next edge. If an overflow or underflow event happens in the same cycle, the flag is set anyway.
- R9: `flush` empties both queues at the next edge. Any write or read in that cycle is discarded, and the read-data outputs and flags are unchanged.
- R10: A change of `dual_mode` empties both queues at the next edge, exactly like `flush`.
- R11: A write and a read on the same queue in one cycle, with that queue neither full nor empty, leave its level unchanged and keep the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dual_mode | input | 1 | 0: one queue, 1: two half-size queues |
| flush | input | 1 | Synchronous empty of both queues |
| clr_err | input | 1 | Clears the sticky error flags |
| fifo_th | input | $clog2(DEPTH)+1 | Low-water threshold in words |
| wr_en | input | 1 | DMA write strobe |
| wr_panel | input | 1 | Target queue in dual mode (0 upper, 1 lower) |
| wr_data | input | DATA_W | DMA write word |
| rd_req_up | input | 1 | Datapath data-request, upper queue |
| rd_data_up | output | DATA_W | Registered read word, upper queue |
| rd_req_lo | input | 1 | Datapath data-request, lower queue |
| rd_data_lo | output | DATA_W | Registered read word, lower queue |
| dma_req_up | output | 1 | Fetch request, upper queue |
| dma_req_lo | output | 1 | Fetch request, lower queue |
| level_up | output | $clog2(DEPTH)+1 | Fill level, upper queue |
| level_lo | output | $clog2(DEPTH)+1 | Fill level, lower queue |
| overflow | output | 1 | Sticky: write to a full queue |
| underflow | output | 1 | Sticky: read from an empty queue |

## Verification
The pair of functions most likely to collide is a DMA push and a datapath pop on the same queue in one cycle. The bench provokes this deliberately at partial fill, and again when the queue is empty and when it is full. In those cases the pop fails while the push lands, or the push is dropped while the pop succeeds. A bench-side queue model judges every cycle by comparing level, read word, fetch request and flags against it. A second collision, a flush or mode change arriving together with a push and a pop, is produced by a random phase that runs the same model.

// File: rtl/disp_fifo_pkg.sv
// Shared definitions for the display DMA input FIFO.
// Assumes nothing beyond standard SystemVerilog packages.
package disp_fifo_pkg;
    // Panel select carried on the DMA write port.
    typedef enum logic {
        PANEL_UPPER = 1'b0,
        PANEL_LOWER = 1'b1
    } panel_e;

    // Number of queues the storage can be split into.
    localparam int NUM_Q = 2;
endpackage

// File: rtl/disp_fifo_store.sv
// Word storage shared by both queues: one write port and NRD registered
// read ports. A read port's output holds its last word when not enabled.
// Assumes the controller never reads and writes the same address in one cycle.
module disp_fifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2048,
    parameter int NRD    = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NRD-1:0]             re,
    input  logic [NRD-1:0][AW-1:0]     raddr,
    output logic [NRD-1:0][DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write the incoming DMA word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Capture the addressed word on a granted read; hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[p] <= '0;
            end else if (re[p]) begin
                rdata[p] <= mem[raddr[p]];
            end
        end

        AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !re[p] |=> $stable(rdata[p])); // R7
    end
endmodule

// File: rtl/disp_fifo_queue.sv
// Pointer and fill-level control for one queue. In single mode the queue
// spans the whole storage; in dual mode it is confined to half BANK.
// Assumes the caller gates push/pop off for a queue unused in single mode.
module disp_fifo_queue #(
    parameter int DEPTH = 2048,
    parameter int BANK  = 0,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          dual,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] level,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          push_drop,
    output logic          pop_miss
);
    localparam logic [AW-1:0] BASE = (BANK != 0) ? {1'b1, {(AW-1){1'b0}}} : '0;

    logic [CW-1:0] cap;
    logic          full;
    logic          empty;

    // Advance a pointer, wrapping inside its half when split.
    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p, input logic split);
        if (split) begin
            return {p[AW-1], p[AW-2:0] + {{(AW-2){1'b0}}, 1'b1}};
        end
        return p + AW'(1);
    endfunction

    // Capacity and status for the current arrangement.
    always_comb begin
        cap       = dual ? CW'(HALF) : CW'(DEPTH);
        full      = (level >= cap);
        empty     = (level == '0);
        push_ok   = push && !full  && !clear;
        pop_ok    = pop  && !empty && !clear;
        push_drop = push && full   && !clear;
        pop_miss  = pop  && empty  && !clear;
    end

    // Pointer and level update; a clear returns the queue to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_addr <= BASE;
            rd_addr <= BASE;
            level   <= '0;
        end else begin
            if (push_ok) begin
                wr_addr <= next_ptr(wr_addr, dual);
            end
            if (pop_ok) begin
                rd_addr <= next_ptr(rd_addr, dual);
            end
            level <= level + CW'(push_ok) - CW'(pop_ok);
        end
    end

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dual == $past(dual)) |-> (level <= cap)); // R3
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (level == '0)); // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clear) |=> (level == $past(level))); // R6
    AST_RW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty && !clear) |=> $stable(level)); // R11
endmodule

// File: rtl/disp_fifo_lowmark.sv
// Registered low-water comparator: raises the fetch request one clock
// after the level is seen below the threshold. Assumes enable is
// constant 1 for a queue that is always in use.
module disp_fifo_lowmark #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] thresh,
    output logic          req
);
    // Register the comparison so the request is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= enable && (level < thresh);
        end
    end

    AST_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !req); // R2
endmodule

// File: rtl/disp_dma_fifo.sv
// Top of the display DMA input FIFO. Routes DMA writes to the upper or
// lower queue, runs the two queue controllers over a shared storage,
// produces per-queue fetch requests and keeps sticky error flags.
// Assumes fifo_th is programmed by the caller, ideally DEPTH-(2*burst+3).
module disp_dma_fifo
    import disp_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2048,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_mode,
    input  logic              flush,
    input  logic              clr_err,
    input  logic [CW-1:0]     fifo_th,
    input  logic              wr_en,
    input  logic              wr_panel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req_up,
    output logic [DATA_W-1:0] rd_data_up,
    input  logic              rd_req_lo,
    output logic [DATA_W-1:0] rd_data_lo,
    output logic              dma_req_up,
    output logic              dma_req_lo,
    output logic [CW-1:0]     level_up,
    output logic [CW-1:0]     level_lo,
    output logic              overflow,
    output logic              underflow
);
    logic                             mode_q;
    logic                             clear;
    logic [NUM_Q-1:0]                 push, pop, push_ok, pop_ok, push_drop, pop_miss;
    logic [NUM_Q-1:0]                 req;
    logic [NUM_Q-1:0][AW-1:0]         waddr_q, raddr_q;
    logic [NUM_Q-1:0][CW-1:0]         lvl;
    logic [NUM_Q-1:0][DATA_W-1:0]     rdata;
    logic                             mem_we;
    logic [AW-1:0]                    mem_waddr;

    // Remember the previous arrangement to detect a mode change.
    always_ff @(posedge clk) begin
        mode_q <= dual_mode;
    end

    // Steer requests: lower queue is active only when split.
    always_comb begin
        clear     = flush || (dual_mode != mode_q);
        push[0]   = wr_en && (!dual_mode || (panel_e'(wr_panel) == PANEL_UPPER));
        push[1]   = wr_en && dual_mode && (panel_e'(wr_panel) == PANEL_LOWER);
        pop[0]    = rd_req_up;
        pop[1]    = rd_req_lo && dual_mode;
        mem_we    = |push_ok;
        mem_waddr = push_ok[1] ? waddr_q[1] : waddr_q[0];
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        disp_fifo_queue #(
            .DEPTH (DEPTH),
            .BANK  (q)
        ) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (clear),
            .dual      (dual_mode),
            .push      (push[q]),
            .pop       (pop[q]),
            .wr_addr   (waddr_q[q]),
            .rd_addr   (raddr_q[q]),
            .level     (lvl[q]),
            .push_ok   (push_ok[q]),
            .pop_ok    (pop_ok[q]),
            .push_drop (push_drop[q]),
            .pop_miss  (pop_miss[q])
        );

        disp_fifo_lowmark #(
            .CW (CW)
        ) u_lowmark (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable ((q == 0) ? 1'b1 : dual_mode),
            .level  (lvl[q]),
            .thresh (fifo_th),
            .req    (req[q])
        );
    end

    disp_fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .NRD    (NUM_Q)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .re    (pop_ok),
        .raddr (raddr_q),
        .rdata (rdata)
    );

    // Sticky error flags; a new event outranks the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overflow  <= (overflow  && !clr_err) || (|push_drop);
            underflow <= (underflow && !clr_err) || (|pop_miss);
        end
    end

    assign rd_data_up = rdata[0];
    assign rd_data_lo = rdata[1];
    assign dma_req_up = req[0];
    assign dma_req_lo = req[1];
    assign level_up   = lvl[0];
    assign level_lo   = lvl[1];

    AST_REQ_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req_up) |-> ($past(level_up) < $past(fifo_th))); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr_err) |=> overflow); // R8
    AST_LO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_mode |=> (level_lo == '0)); // R2
endmodule

// File: tb/tb_disp_dma_fifo.sv
`timescale 1ns/1ps
module tb_disp_dma_fifo;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n, dual_mode, flush, clr_err, wr_en, wr_panel;
    logic          rd_req_up, rd_req_lo;
    logic [CW-1:0] fifo_th;
    logic [DW-1:0] wr_data, rd_data_up, rd_data_lo;
    logic          dma_req_up, dma_req_lo, overflow, underflow;
    logic [CW-1:0] level_up, level_lo;

    always #2.5 clk = ~clk;

    disp_dma_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .flush(flush),
        .clr_err(clr_err), .fifo_th(fifo_th), .wr_en(wr_en), .wr_panel(wr_panel),
        .wr_data(wr_data), .rd_req_up(rd_req_up), .rd_data_up(rd_data_up),
        .rd_req_lo(rd_req_lo), .rd_data_lo(rd_data_lo), .dma_req_up(dma_req_up),
        .dma_req_lo(dma_req_lo), .level_up(level_up), .level_lo(level_lo),
        .overflow(overflow), .underflow(underflow)
    );

    int vecs = 0;
    int errs = 0;
    int th_val = 0;
    logic [DW-1:0] mq0[$];
    logic [DW-1:0] mq1[$];
    logic [DW-1:0] m_rd0 = '0, m_rd1 = '0;
    logic m_ovf = 1'b0, m_unf = 1'b0, m_mode = 1'b0;

    task automatic chk(input string r, input string what, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare 1ns later.
    task automatic step(input logic md, input logic we, input logic pnl, input logic [DW-1:0] d,
                        input logic ru, input logic rl, input logic fl, input logic ce);
        int pre0, pre1, cap;
        logic clr, ev_o, ev_u;
        @(negedge clk);
        dual_mode = md; wr_en = we; wr_panel = pnl; wr_data = d;
        rd_req_up = ru; rd_req_lo = rl; flush = fl; clr_err = ce;
        fifo_th = CW'(th_val);
        pre0 = mq0.size(); pre1 = mq1.size();
        @(posedge clk);
        clr = fl || (md != m_mode);
        cap = md ? HALF : DEPTH;
        ev_o = 1'b0; ev_u = 1'b0;
        if (clr) begin
            mq0.delete(); mq1.delete();
        end else begin
            if (ru) begin
                if (pre0 > 0) m_rd0 = mq0.pop_front(); else ev_u = 1'b1;
            end
            if (md && rl) begin
                if (pre1 > 0) m_rd1 = mq1.pop_front(); else ev_u = 1'b1;
            end
            if (we) begin
                if (md && pnl) begin
                    if (pre1 < cap) mq1.push_back(d); else ev_o = 1'b1;
                end else begin
                    if (pre0 < cap) mq0.push_back(d); else ev_o = 1'b1;
                end
            end
        end
        m_ovf = (m_ovf && !ce) || ev_o;
        m_unf = (m_unf && !ce) || ev_u;
        m_mode = md;
        #1;
        chk(md ? "R3" : "R2", "level_up", int'(level_up), mq0.size());
        chk(md ? "R3" : "R2", "level_lo", int'(level_lo), mq1.size());
        chk("R4", "rd_data_up", int'(rd_data_up), int'(m_rd0));
        chk("R4", "rd_data_lo", int'(rd_data_lo), int'(m_rd1));
        chk("R5", "dma_req_up", int'(dma_req_up), int'(pre0 < th_val));
        chk("R5", "dma_req_lo", int'(dma_req_lo), int'(md && (pre1 < th_val)));
        chk("R6", "overflow", int'(overflow), int'(m_ovf));
        chk("R7", "underflow", int'(underflow), int'(m_unf));
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual 150000 cycles expected completion sooner");
        summary();
    end

    initial begin
        logic [31:0] lfsr;
        int base;
        rst_n = 1'b0; dual_mode = 1'b0; flush = 1'b0; clr_err = 1'b0;
        wr_en = 1'b0; wr_panel = 1'b0; wr_data = '0; rd_req_up = 1'b0;
        rd_req_lo = 1'b0; fifo_th = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1", "level_up", int'(level_up), 0);
        chk("R1", "level_lo", int'(level_lo), 0);
        chk("R1", "dma_req_up", int'(dma_req_up), 0);
        chk("R1", "dma_req_lo", int'(dma_req_lo), 0);
        chk("R1", "overflow", int'(overflow), 0);
        chk("R1", "underflow", int'(underflow), 0);
        chk("R1", "rd_data_up", int'(rd_data_up), 0);
        rst_n = 1'b1;
        m_mode = 1'b0;

        // Single mode: sweep every threshold, fill past full, drain past empty.
        for (int t = 0; t <= DEPTH; t++) begin
            th_val = t;
            base = t * 64;
            step(0, 0, 0, '0, 0, 0, 1, 1);
            chk("R9", "level_up after flush", int'(level_up), 0);
            for (int i = 0; i <= DEPTH; i++)
                step(0, 1, i[0], DW'(base + i), 0, i[1], 0, 0);
            chk("R6", "overflow after full write", int'(overflow), 1);
            step(0, 0, 0, '0, 0, 1, 0, 1);
            chk("R8", "overflow cleared", int'(overflow), 0);
            chk("R2", "rd_data_lo idle in single mode", int'(rd_data_lo), int'(m_rd1));
            for (int i = 0; i < DEPTH / 2; i++)
                step(0, 0, 0, '0, 1, 0, 0, 0);
            // R11: concurrent write and read at half fill.
            step(0, 1, 1, DW'(base + 40), 1, 0, 0, 0);
            chk("R11", "level_up held", int'(level_up), DEPTH / 2);
            for (int i = 0; i <= DEPTH / 2 + 1; i++)
                step(0, 0, 0, '0, 1, 0, 0, 0);
            chk("R7", "underflow after empty read", int'(underflow), 1);
            step(0, 0, 0, '0, 1, 0, 0, 1);
            chk("R8", "event outranks clear", int'(underflow), 1);
        end

        // Dual mode: mode change clears, then fill both halves past full.
        for (int t = 0; t <= HALF + 1; t++) begin
            th_val = t;
            base = 4096 + t * 64;
            step(0, 1, 0, DW'(base), 0, 0, 0, 0);
            step(1, 0, 0, '0, 0, 0, 0, 1);
            chk("R10", "level_up after mode change", int'(level_up), 0);
            for (int i = 0; i < 2 * HALF + 2; i++)
                step(1, 1, i[0], DW'(base + i), 0, 0, 0, 0);
            chk("R3", "level_lo full", int'(level_lo), HALF);
            step(1, 1, 1, DW'(base + 50), 1, 1, 0, 0);
            for (int i = 0; i <= HALF; i++)
                step(1, 0, 0, '0, 1, 1, 0, 0);
            step(1, 1, 1, DW'(base + 60), 0, 1, 0, 1);
        end

        // Random phase with flushes and mode changes.
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 4000; n++) begin
            logic md;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            md = (lfsr[31:27] == 5'd0) ? !m_mode : m_mode;
            if (lfsr[26:23] == 4'd0) th_val = int'(lfsr[20:16]);
            step(md, lfsr[0] | lfsr[1], lfsr[2], DW'(lfsr[19:4]), lfsr[5] & lfsr[6],
                 lfsr[7] | lfsr[8], (lfsr[14:9] == 6'd0), (lfsr[22:18] == 5'd0));
        end
        summary();
    end
endmodule